// File: doc/BRIEF.md
# Serial NOR Flash Range Eraser

This block erases an address range of a serial NOR flash device that sits on a SPI bus. A requester presents a start address, a byte length and a choice of erase unit on a valid/ready handshake. The block first checks the request: the range must fit inside the device, and the length must be a whole number of erase units. A rejected request raises the error output and sends nothing on the bus.

An accepted request whose length covers the whole device is carried out as one chip-wide erase command. Any other length is carried out as a loop of unit erases, from the start address upward, one unit per step. Every erase command is preceded by the same two steps. First the status register is read until its busy bit is clear. Then a separate write-enable frame is sent. Status polling is bounded: if the device stays busy for too many reads in a row, the block gives up, flags an error and returns to idle.

The serial side is a byte shifter in SPI mode 0 with a fixed clock divider. Chip select is driven by the sequencer, which holds it high for a guard interval between frames.

Top module: `nor_range_eraser`

## Requirements
- R1: A request with start address plus length greater than 2^DEV_LOG2 bytes is rejected. `err` is set, no chip-select frame is sent and `req_ready` stays high. A range that ends exactly at the device end is accepted.
- R2: A request whose length is not a multiple of the selected unit size is rejected in the same way as R1.
- R3: When the length equals 2^DEV_LOG2, the erase frame is the single byte 0xC7 and no unit loop is run.
- R4: Otherwise the block sends one erase frame per unit. Each frame carries the opcode followed by a 24-bit address, most significant byte first. The first address is the start address and each later address is one unit size higher. The number of erase frames equals length divided by unit size.
- R5: `req_big`=0 selects 2^SMALL_LOG2-byte units with opcode 0x20. `req_big`=1 selects 2^BIG_LOG2-byte units with opcode 0xD8.
- R6: Before each erase the block sends status-read frames. Each frame is opcode 0x05 followed by one received byte. Bit 0 of the received byte set to 1 means busy. Polling repeats until that bit reads 0.
- R7: After POLL_LIMIT consecutive busy status reads, the block sets `err`, sends no further frame and returns to idle.
- R8: Each erase frame is preceded, directly after the final idle status read, by a one-byte frame 0x06.
- R9: Bytes are shifted in SPI mode 0, most significant bit first. `spi_sck` is low whenever `spi_cs_n` is high. `spi_cs_n` stays high for at least 4*CLK_HALF clock cycles (two SPI clock periods) between frames.
- R10: On success `done` is high for exactly one cycle and `err` is low. `err` keeps its value until the next request is accepted. `req_ready` is high only while the block is idle.
- R11: An in-range request of length zero completes with a `done` pulse and sends no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; request taken when both high |
| req_addr | input | 24 | Start byte address |
| req_len | input | 25 | Length in bytes |
| req_big | input | 1 | 0: small erase unit, 1: large erase unit |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | Failure flag (reject or poll timeout) |
| spi_sck | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
A rejected request sets `err` at the clock edge that accepts it, so it is visible at the next falling edge with no frame sent. A `done` pulse or a timeout `err` appears at the same edge that raises chip select after the last frame. The bench therefore waits for these results on falling edges and then checks that `done` is low again one cycle later. Each frame is compared against the scoreboard as chip select rises. The flash model changes its busy count only at frame ends, which fixes exactly how many status reads each erase costs, and those frames are pushed as expected items before the request is issued.

// File: rtl/nre_pkg.sv
package nre_pkg;
  localparam int ADDR_W = 24;
  localparam int LEN_W  = ADDR_W + 1;

  localparam logic [7:0] OP_STATUS = 8'h05;
  localparam logic [7:0] OP_WR_EN  = 8'h06;
  localparam logic [7:0] OP_CHIP   = 8'hC7;
  localparam logic [7:0] OP_SMALL  = 8'h20;
  localparam logic [7:0] OP_BIG    = 8'hD8;

  typedef enum logic [2:0] {ST_IDLE, ST_GAP, ST_LOAD, ST_WAIT, ST_EVAL} seq_st_e;
  typedef enum logic [1:0] {FR_STAT, FR_WREN, FR_ERASE} frame_e;
endpackage

// File: rtl/nre_req_check.sv
module nre_req_check
  import nre_pkg::*;
#(
  parameter int DEV_LOG2   = 20,
  parameter int SMALL_LOG2 = 12,
  parameter int BIG_LOG2   = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  logic              big,
  output logic              ok,
  output logic              whole,
  output logic [LEN_W-1:0]  unit_bytes
);
  localparam int SUM_W = ADDR_W + 2;
  localparam logic [SUM_W-1:0] DEV_BYTES = SUM_W'(1) << DEV_LOG2;
  localparam logic [LEN_W-1:0] SMALL_B   = LEN_W'(1) << SMALL_LOG2;
  localparam logic [LEN_W-1:0] BIG_B     = LEN_W'(1) << BIG_LOG2;

  logic [SUM_W-1:0] end_pos;
  logic             fits, aligned;

  always_comb begin
    unit_bytes = big ? BIG_B : SMALL_B;
    end_pos    = SUM_W'(addr) + SUM_W'(len);
    fits       = end_pos <= DEV_BYTES;
    aligned    = (len & (unit_bytes - LEN_W'(1))) == '0;
    ok         = fits && aligned;
    whole      = SUM_W'(len) == DEV_BYTES;
  end
endmodule

// File: rtl/nre_spi_byte.sv
module nre_spi_byte #(
  parameter int CLK_HALF = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx
);
  localparam int DW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;

  logic          active;
  logic [DW-1:0] div;
  logic [2:0]    bitn;
  logic [7:0]    sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      div    <= '0;
      bitn   <= '0;
      sh     <= '0;
      sck    <= 1'b0;
      mosi   <= 1'b0;
      done   <= 1'b0;
      rx     <= '0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        active <= 1'b1;
        sh     <= tx;
        mosi   <= tx[7];
        sck    <= 1'b0;
        div    <= '0;
        bitn   <= '0;
      end else if (active) begin
        if (div == DW'(CLK_HALF - 1)) begin
          div <= '0;
          if (!sck) begin
            sck <= 1'b1;
            rx  <= {rx[6:0], miso};
          end else begin
            sck <= 1'b0;
            if (bitn == 3'd7) begin
              active <= 1'b0;
              done   <= 1'b1;
              mosi   <= 1'b0;
            end else begin
              bitn <= bitn + 3'd1;
              sh   <= {sh[6:0], 1'b0};
              mosi <= sh[6];
            end
          end
        end else begin
          div <= div + DW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/nre_seq.sv
module nre_seq
  import nre_pkg::*;
#(
  parameter int POLL_LIMIT = 100000,
  parameter int GAP_CYC    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_big,
  input  logic              chk_ok,
  input  logic              chk_whole,
  input  logic [LEN_W-1:0]  chk_unit,
  input  logic              spi_done,
  input  logic [7:0]        spi_rx,
  output logic              spi_start,
  output logic [7:0]        spi_tx,
  output logic              cs_n,
  output logic              done,
  output logic              err
);
  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam int GW = $clog2(GAP_CYC + 1);

  seq_st_e           st;
  frame_e            kind;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  remain, unit;
  logic              big_q, whole_q;
  logic [1:0]        idx;
  logic [PW-1:0]     polls;
  logic [GW-1:0]     gap;
  logic [7:0]        byte_now;
  logic              last_byte;

  assign req_ready = (st == ST_IDLE);

  always_comb begin
    byte_now  = 8'h00;
    last_byte = 1'b1;
    unique case (kind)
      FR_STAT: begin
        byte_now  = (idx == 2'd0) ? OP_STATUS : 8'h00;
        last_byte = (idx == 2'd1);
      end
      FR_WREN: byte_now = OP_WR_EN;
      default: begin
        if (whole_q) begin
          byte_now = OP_CHIP;
        end else begin
          last_byte = (idx == 2'd3);
          unique case (idx)
            2'd0:    byte_now = big_q ? OP_BIG : OP_SMALL;
            2'd1:    byte_now = cur_addr[23:16];
            2'd2:    byte_now = cur_addr[15:8];
            default: byte_now = cur_addr[7:0];
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      kind      <= FR_STAT;
      cur_addr  <= '0;
      remain    <= '0;
      unit      <= '0;
      big_q     <= 1'b0;
      whole_q   <= 1'b0;
      idx       <= '0;
      polls     <= '0;
      gap       <= '0;
      spi_start <= 1'b0;
      spi_tx    <= '0;
      cs_n      <= 1'b1;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      spi_start <= 1'b0;
      done      <= 1'b0;
      unique case (st)
        ST_IDLE: if (req_valid) begin
          err <= 1'b0;
          if (!chk_ok) begin
            err <= 1'b1;
          end else if (req_len == '0) begin
            done <= 1'b1;
          end else begin
            cur_addr <= req_addr;
            remain   <= req_len;
            unit     <= chk_unit;
            big_q    <= req_big;
            whole_q  <= chk_whole;
            kind     <= FR_STAT;
            polls    <= '0;
            gap      <= '0;
            st       <= ST_GAP;
          end
        end
        ST_GAP: begin
          gap <= gap + GW'(1);
          if (gap == GW'(GAP_CYC - 1)) begin
            cs_n <= 1'b0;
            idx  <= '0;
            st   <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          spi_start <= 1'b1;
          spi_tx    <= byte_now;
          st        <= ST_WAIT;
        end
        ST_WAIT: if (spi_done) begin
          if (last_byte) begin
            st <= ST_EVAL;
          end else begin
            idx <= idx + 2'd1;
            st  <= ST_LOAD;
          end
        end
        default: begin
          cs_n <= 1'b1;
          gap  <= '0;
          st   <= ST_GAP;
          unique case (kind)
            FR_STAT: begin
              if (!spi_rx[0]) begin
                kind <= FR_WREN;
              end else if (polls == PW'(POLL_LIMIT - 1)) begin
                err <= 1'b1;
                st  <= ST_IDLE;
              end else begin
                polls <= polls + PW'(1);
              end
            end
            FR_WREN: kind <= FR_ERASE;
            default: begin
              if (whole_q || remain == unit) begin
                done <= 1'b1;
                st   <= ST_IDLE;
              end else begin
                cur_addr <= cur_addr + unit[ADDR_W-1:0];
                remain   <= remain - unit;
                kind     <= FR_STAT;
                polls    <= '0;
              end
            end
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/nor_range_eraser.sv
module nor_range_eraser
  import nre_pkg::*;
#(
  parameter int DEV_LOG2   = 20,
  parameter int SMALL_LOG2 = 12,
  parameter int BIG_LOG2   = 16,
  parameter int POLL_LIMIT = 100000,
  parameter int CLK_HALF   = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [23:0] req_addr,
  input  logic [24:0] req_len,
  input  logic        req_big,
  output logic        done,
  output logic        err,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int GAP_CYC = 4 * CLK_HALF;

  logic             chk_ok, chk_whole;
  logic [LEN_W-1:0] chk_unit;
  logic             spi_start, spi_done;
  logic [7:0]       spi_tx, spi_rx;

  nre_req_check #(
    .DEV_LOG2(DEV_LOG2), .SMALL_LOG2(SMALL_LOG2), .BIG_LOG2(BIG_LOG2)
  ) check_i (
    .addr(req_addr), .len(req_len), .big(req_big),
    .ok(chk_ok), .whole(chk_whole), .unit_bytes(chk_unit)
  );

  nre_seq #(.POLL_LIMIT(POLL_LIMIT), .GAP_CYC(GAP_CYC)) seq_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_big(req_big),
    .chk_ok(chk_ok), .chk_whole(chk_whole), .chk_unit(chk_unit),
    .spi_done(spi_done), .spi_rx(spi_rx),
    .spi_start(spi_start), .spi_tx(spi_tx),
    .cs_n(spi_cs_n), .done(done), .err(err)
  );

  nre_spi_byte #(.CLK_HALF(CLK_HALF)) shift_i (
    .clk(clk), .rst(rst), .start(spi_start), .tx(spi_tx), .miso(spi_miso),
    .sck(spi_sck), .mosi(spi_mosi), .done(spi_done), .rx(spi_rx)
  );
endmodule

// File: rtl/nre_chk.sv
module nre_chk #(
  parameter int GAP_CYC = 8
) (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic sck,
  input logic done,
  input logic err,
  input logic req_ready
);
  localparam int CW = $clog2(GAP_CYC + 1) + 1;
  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst || !cs_n) hi_cnt <= '0;
    else if (hi_cnt < CW'(GAP_CYC)) hi_cnt <= hi_cnt + CW'(1);
  end

  assert_cs_gap_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> hi_cnt >= CW'(GAP_CYC));
  assert_sck_idle_R9: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sck);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_no_err_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !err);
  assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> !req_ready);
  assert_err_goes_idle_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> req_ready);
endmodule

bind nor_range_eraser nre_chk #(.GAP_CYC(GAP_CYC)) chk_i (
  .clk(clk), .rst(rst), .cs_n(spi_cs_n), .sck(spi_sck),
  .done(done), .err(err), .req_ready(req_ready)
);

// File: tb/nor_range_eraser_tb_top.sv
`timescale 1ns/1ps
module nor_range_eraser_tb_top;
  localparam int DEV_LOG2 = 16;
  localparam int SMALL_LOG2 = 12;
  localparam int BIG_LOG2 = 14;
  localparam int POLL_LIMIT = 8;
  localparam int CLK_HALF = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_big = 1'b0;
  logic [23:0] req_addr = '0;
  logic [24:0] req_len = '0;
  logic req_ready, done, err, spi_sck, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;

  always #4 clk = ~clk;

  nor_range_eraser #(
    .DEV_LOG2(DEV_LOG2), .SMALL_LOG2(SMALL_LOG2), .BIG_LOG2(BIG_LOG2),
    .POLL_LIMIT(POLL_LIMIT), .CLK_HALF(CLK_HALF)
  ) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_big(req_big),
    .done(done), .err(err), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // scoreboard of expected frames
  int          exp_n[$];
  logic [39:0] exp_d[$];
  string       exp_t[$];

  task automatic push_frame(int n, logic [39:0] d, string tag);
    exp_n.push_back(n); exp_d.push_back(d); exp_t.push_back(tag);
  endtask

  task automatic push_unit(int busy_reads, logic [7:0] op, logic [23:0] a, string tag);
    for (int i = 0; i <= busy_reads; i++) push_frame(2, 40'h0500, tag);
    push_frame(1, 40'h06, tag);
    push_frame(4, {8'h00, op, a}, tag);
  endtask

  // flash model and monitor, sampled on falling clock edges
  logic [39:0] cur = '0;
  int nbits = 0, busy_left = 0, busy_after = 0, hi_cyc = 0;
  logic sck_q = 1'b0, cs_q = 1'b1;
  bit seen_frame = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (!spi_cs_n && cs_q) begin
        if (seen_frame) chk(hi_cyc >= 4*CLK_HALF, "R9", "chip-select high gap", hi_cyc, 4*CLK_HALF);
        chk(spi_sck == 1'b0, "R9", "sck at frame start", spi_sck, 0);
        seen_frame = 1; cur = '0; nbits = 0; spi_miso = 1'b0;
      end
      if (spi_cs_n) hi_cyc++; else hi_cyc = 0;
      if (!spi_cs_n && spi_sck && !sck_q) begin
        cur = {cur[38:0], spi_mosi}; nbits++;
      end
      if (!spi_cs_n && !spi_sck && sck_q)
        spi_miso = (nbits == 15) ? (busy_left != 0) : 1'b0;
      if (spi_cs_n && !cs_q) begin
        int n;
        logic [7:0] op;
        n = nbits / 8;
        op = (n > 0) ? cur[8*n-1 -: 8] : 8'h00;
        if (exp_n.size() == 0) begin
          chk(0, "R1/R7", "unexpected frame", cur, 0);
        end else begin
          int en; logic [39:0] ed; string et;
          en = exp_n.pop_front(); ed = exp_d.pop_front(); et = exp_t.pop_front();
          chk(n == en, et, "frame byte count", n, en);
          chk(cur == ed, et, "frame bytes", cur, ed);
        end
        if (op == 8'h05 && busy_left > 0) busy_left--;
        if (op == 8'h20 || op == 8'hD8 || op == 8'hC7) busy_left = busy_after;
      end
      sck_q = spi_sck; cs_q = spi_cs_n;
    end
  end

  task automatic send_req(logic [23:0] a, logic [24:0] l, logic b);
    while (!req_ready) @(negedge clk);
    req_addr = a; req_len = l; req_big = b; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_result(bit exp_done, string tag);
    bit gd = 0, ge = 0;
    if (done) gd = 1;
    else if (err && req_ready) ge = 1;
    for (int i = 0; i < 20000 && !gd && !ge; i++) begin
      @(negedge clk);
      if (done) gd = 1;
      else if (err && req_ready) ge = 1;
    end
    chk(gd == exp_done, tag, "done seen", gd, exp_done);
    chk(ge == !exp_done, tag, "err seen", ge, !exp_done);
    if (gd) begin
      @(negedge clk);
      chk(!done && !err, "R10", "done one cycle, err low", {done, err}, 0);
    end
    repeat (80) @(negedge clk);
    chk(exp_n.size() == 0, tag, "expected frames left", exp_n.size(), 0);
    chk(req_ready && spi_cs_n, "R10", "idle after request", {req_ready, spi_cs_n}, 2'b11);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(spi_cs_n && !spi_sck && req_ready && !done && !err, "R10", "reset state",
        {spi_cs_n, spi_sck, req_ready, done, err}, 5'b10100);

    // R4 R6 R8: small units, busy before each erase
    busy_left = 1; busy_after = 2;
    push_unit(1, 8'h20, 24'h001000, "R4/R6/R8");
    push_unit(2, 8'h20, 24'h002000, "R4/R6/R8");
    send_req(24'h001000, 25'h2000, 1'b0);
    wait_result(1, "R4");

    // R5: large units
    busy_left = 0; busy_after = 0;
    push_unit(0, 8'hD8, 24'h004000, "R5");
    push_unit(0, 8'hD8, 24'h008000, "R5");
    send_req(24'h004000, 25'h8000, 1'b1);
    wait_result(1, "R5");

    // R1 boundary: range ends exactly at device end
    push_unit(0, 8'h20, 24'h00E000, "R1");
    push_unit(0, 8'h20, 24'h00F000, "R1");
    send_req(24'h00E000, 25'h2000, 1'b0);
    wait_result(1, "R1");

    // R3: whole device
    busy_left = 1;
    push_frame(2, 40'h0500, "R3"); push_frame(2, 40'h0500, "R3");
    push_frame(1, 40'h06, "R3"); push_frame(1, 40'hC7, "R3");
    send_req(24'h000000, 25'h10000, 1'b0);
    wait_result(1, "R3");

    // R1 reject: past device end
    send_req(24'h00F000, 25'h2000, 1'b0);
    wait_result(0, "R1");

    // R2 reject: not a unit multiple, both unit sizes
    send_req(24'h000000, 25'h1800, 1'b0);
    wait_result(0, "R2");
    send_req(24'h000000, 25'h1000, 1'b1);
    wait_result(0, "R2");

    // R7 timeout: device stays busy
    busy_left = 20;
    for (int i = 0; i < POLL_LIMIT; i++) push_frame(2, 40'h0500, "R7");
    send_req(24'h002000, 25'h1000, 1'b0);
    wait_result(0, "R7");
    chk(err, "R7", "err held after timeout", err, 1);

    // R11 zero length; R10 err cleared by accepted request
    busy_left = 0;
    send_req(24'h003000, 25'h0, 1'b0);
    wait_result(1, "R11");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule